// File: doc/BRIEF.md
# Interleaved-Parity Hamming SEC Bus Codec

This block guards narrow on-chip bus words against a single flipped wire. Each 4-bit data nibble travels as a 7-wire codeword. The three check wires are not grouped at the power-of-two slots. They sit at odd positions 1, 3 and 5, between the payload wires. The block has two independent sides. The transmit side turns a strobed nibble into a registered codeword. The receive side takes a strobed codeword, builds a 3-bit syndrome, inverts the one wire that the syndrome points at, and returns the repaired nibble. With the nibble it returns a per-lane error flag and the raw syndrome, for debug.

The `LANES` parameter places several identical 4-bit lanes side by side. Each lane uses its own slice of the bus and has its own flag and syndrome. Both sides have one register stage with a valid bit carried alongside. A double error inside one lane is not detected: it is taken as a single error and corrected to the wrong nibble.

Top module: `hsec_bus_codec`

## Requirements
- R1: Codeword position p (1..7) is bus bit p-1. Data bits D1..D4 are nibble bits 0..3 and ride on bus bits 1, 3, 5 and 6. Parity bits P1, P2 and P3 ride on bus bits 0, 2 and 4.
- R2: The parity bits are P1 = D2^D3^D4, P2 = D1^D3^D4 and P3 = D1^D2^D4.
- R3: Every captured transmit nibble and every captured received word shows its result exactly one clock later. The matching output valid is high in that cycle and low one cycle after a cycle with the input valid low.
- R4: A received word with a zero syndrome returns its data bits unchanged, with the lane error flag low.
- R5: The syndrome output bits {s3,s2,s1} are bits [2:0] of the lane slice. A single flipped wire at positions 1..7 gives 001, 110, 010, 101, 100, 011 and 111 respectively.
- R6: A single flipped data wire is inverted back, the exact transmitted nibble is output, and the lane error flag is high.
- R7: A single flipped parity wire raises the lane error flag and leaves the output nibble equal to the transmitted one.
- R8: A synchronous active-high reset clears the bus, both valids, the data, the flags and the syndromes to zero at the next clock edge.
- R9: While an input valid is low, the corresponding registered outputs (bus or data, flag, syndrome) hold their previous values.
- R10: Lane k uses bus bits 7k..7k+6, data bits 4k..4k+3, error flag bit k and syndrome bits 3k..3k+2. An error in one lane does not disturb another lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data_i | input | 4*LANES | Nibbles to encode |
| tx_valid_i | input | 1 | Transmit strobe |
| bus_o | output | 7*LANES | Registered codewords |
| bus_valid_o | output | 1 | Codeword valid |
| rx_bus_i | input | 7*LANES | Received codewords |
| rx_valid_i | input | 1 | Receive strobe |
| rx_data_o | output | 4*LANES | Corrected nibbles |
| rx_valid_o | output | 1 | Corrected data valid |
| rx_err_o | output | LANES | Per-lane single-error flag |
| rx_syn_o | output | 3*LANES | Per-lane raw syndrome |

## Verification
The bench builds the codec with `LANES` = 2, so that lane isolation can be observed. Lane 0 steps through all 16 nibbles and lane 1 carries their complements. Each nibble pair is sent once with no error and then with a single flipped wire at every position. The two lanes are corrupted at different positions in the same cycle, so a syndrome or mask that leaks into the neighbouring slice shows up as a miscompare.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    localparam int NIB_W = 4;
    localparam int CW_W  = 7;
    localparam int SYN_W = 3;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CW_W-1:0]  cw_t;
    typedef logic [SYN_W-1:0] syn_t;

    // Bit index = codeword position - 1; parity at odd positions 1,3,5.
    function automatic cw_t hsec_encode(input nib_t d);
        cw_t c;
        c[1] = d[0];
        c[3] = d[1];
        c[5] = d[2];
        c[6] = d[3];
        c[0] = d[1] ^ d[2] ^ d[3];
        c[2] = d[0] ^ d[2] ^ d[3];
        c[4] = d[0] ^ d[1] ^ d[3];
        return c;
    endfunction

    function automatic syn_t hsec_syndrome(input cw_t c);
        syn_t s;
        s[0] = c[0] ^ c[3] ^ c[5] ^ c[6];
        s[1] = c[2] ^ c[1] ^ c[5] ^ c[6];
        s[2] = c[4] ^ c[1] ^ c[3] ^ c[6];
        return s;
    endfunction

    function automatic nib_t hsec_extract(input cw_t c);
        return {c[6], c[5], c[3], c[1]};
    endfunction

    // Column of the check matrix for bit index i: syndrome of a lone one.
    function automatic syn_t hsec_column(input int i);
        cw_t one;
        one    = '0;
        one[i] = 1'b1;
        return hsec_syndrome(one);
    endfunction

endpackage

// File: rtl/hsec_enc_lane.sv
module hsec_enc_lane
    import hsec_pkg::*;
(
    input  logic [NIB_W-1:0] data_i,
    output logic [CW_W-1:0]  cw_o
);

    always_comb begin
        cw_o = hsec_encode(data_i);
    end

endmodule

// File: rtl/hsec_dec_lane.sv
module hsec_dec_lane
    import hsec_pkg::*;
(
    input  logic [CW_W-1:0]  cw_i,
    output logic [NIB_W-1:0] data_o,
    output logic             err_o,
    output logic [SYN_W-1:0] syn_o
);

    logic [SYN_W-1:0] syn;
    logic [CW_W-1:0]  flip;
    logic [CW_W-1:0]  fixed;

    always_comb begin
        syn = hsec_syndrome(cw_i);
    end

    // One comparator per wire: a wire flips when its column matches.
    for (genvar i = 0; i < CW_W; i++) begin : g_flip
        always_comb begin
            flip[i] = (syn == hsec_column(i));
        end
    end

    always_comb begin
        fixed  = cw_i ^ flip;
        data_o = hsec_extract(fixed);
        err_o  = |syn;
        syn_o  = syn;
    end

endmodule

// File: rtl/hsec_bus_codec.sv
module hsec_bus_codec
    import hsec_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES*4-1:0]     tx_data_i,
    input  logic                   tx_valid_i,
    output logic [LANES*7-1:0]     bus_o,
    output logic                   bus_valid_o,
    input  logic [LANES*7-1:0]     rx_bus_i,
    input  logic                   rx_valid_i,
    output logic [LANES*4-1:0]     rx_data_o,
    output logic                   rx_valid_o,
    output logic [LANES-1:0]       rx_err_o,
    output logic [LANES*3-1:0]     rx_syn_o
);

    localparam int DATA_W = LANES * NIB_W;
    localparam int BUS_W  = LANES * CW_W;
    localparam int SYN_A  = LANES * SYN_W;

    typedef struct packed {
        logic [BUS_W-1:0]  bus;
        logic              bus_vld;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  err;
        logic [SYN_A-1:0]  syn;
        logic              data_vld;
    } state_t;

    state_t st_d, st_q;

    logic [BUS_W-1:0]  enc_cw;
    logic [DATA_W-1:0] dec_data;
    logic [LANES-1:0]  dec_err;
    logic [SYN_A-1:0]  dec_syn;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        hsec_enc_lane u_enc (
            .data_i (tx_data_i[k*NIB_W +: NIB_W]),
            .cw_o   (enc_cw[k*CW_W +: CW_W])
        );
        hsec_dec_lane u_dec (
            .cw_i   (rx_bus_i[k*CW_W +: CW_W]),
            .data_o (dec_data[k*NIB_W +: NIB_W]),
            .err_o  (dec_err[k]),
            .syn_o  (dec_syn[k*SYN_W +: SYN_W])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.bus_vld  = tx_valid_i;
        st_d.data_vld = rx_valid_i;
        if (tx_valid_i) begin
            st_d.bus = enc_cw;
        end
        if (rx_valid_i) begin
            st_d.data = dec_data;
            st_d.err  = dec_err;
            st_d.syn  = dec_syn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_o       = st_q.bus;
    assign bus_valid_o = st_q.bus_vld;
    assign rx_data_o   = st_q.data;
    assign rx_valid_o  = st_q.data_vld;
    assign rx_err_o    = st_q.err;
    assign rx_syn_o    = st_q.syn;

endmodule

// File: rtl/hsec_bus_codec_chk.sv
module hsec_bus_codec_chk
    import hsec_pkg::*;
#(
    parameter int LANES = 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tx_valid_i,
    input logic [LANES*7-1:0]     bus_o,
    input logic                   bus_valid_o,
    input logic [LANES*7-1:0]     rx_bus_i,
    input logic                   rx_valid_i,
    input logic [LANES*4-1:0]     rx_data_o,
    input logic                   rx_valid_o,
    input logic [LANES-1:0]       rx_err_o,
    input logic [LANES*3-1:0]     rx_syn_o
);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (bus_o == '0 && !bus_valid_o && rx_data_o == '0 &&
                 !rx_valid_o && rx_err_o == '0 && rx_syn_o == '0));

    // R3
    tx_valid_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid_i |=> bus_valid_o);

    // R3
    tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_valid_i |=> !bus_valid_o);

    // R3
    rx_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_i |=> rx_valid_o);

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_i |=> ($stable(rx_data_o) && $stable(rx_syn_o) && $stable(rx_err_o)));

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_valid_i |=> $stable(bus_o));

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        // R2
        codeword_chk: assert property (@(posedge clk) disable iff (rst)
            bus_valid_o |-> (hsec_syndrome(bus_o[k*7 +: 7]) == '0));

        // R4
        clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (rx_valid_i && hsec_syndrome(rx_bus_i[k*7 +: 7]) == '0) |=>
            (!rx_err_o[k] &&
             rx_data_o[k*4 +: 4] == $past(hsec_extract(rx_bus_i[k*7 +: 7]))));
    end

endmodule

bind hsec_bus_codec hsec_bus_codec_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_valid_i  (tx_valid_i),
    .bus_o       (bus_o),
    .bus_valid_o (bus_valid_o),
    .rx_bus_i    (rx_bus_i),
    .rx_valid_i  (rx_valid_i),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o),
    .rx_err_o    (rx_err_o),
    .rx_syn_o    (rx_syn_o)
);

// File: tb/hsec_bus_codec_tb.sv
module hsec_bus_codec_tb;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 2;
    localparam int DW         = LANES * 4;
    localparam int BW         = LANES * 7;
    localparam int SW         = LANES * 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] tx_data_i = '0;
    logic          tx_valid_i = 1'b0;
    logic [BW-1:0] bus_o;
    logic          bus_valid_o;
    logic [BW-1:0] rx_bus_i = '0;
    logic          rx_valid_i = 1'b0;
    logic [DW-1:0] rx_data_o;
    logic          rx_valid_o;
    logic [LANES-1:0] rx_err_o;
    logic [SW-1:0] rx_syn_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic [BW-1:0]    bus;
        logic [DW-1:0]    data;
        logic [LANES-1:0] err;
        logic [SW-1:0]    syn;
        logic [LANES-1:0] par_hit;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hsec_bus_codec #(.LANES(LANES)) u_dut (
        .clk (clk), .rst (rst),
        .tx_data_i (tx_data_i), .tx_valid_i (tx_valid_i),
        .bus_o (bus_o), .bus_valid_o (bus_valid_o),
        .rx_bus_i (rx_bus_i), .rx_valid_i (rx_valid_i),
        .rx_data_o (rx_data_o), .rx_valid_o (rx_valid_o),
        .rx_err_o (rx_err_o), .rx_syn_o (rx_syn_o)
    );

    // Layout from R1, parity from R2.
    function automatic logic [6:0] ref_cw(input logic [3:0] d);
        return {d[3], d[2], d[0]^d[1]^d[3], d[1], d[0]^d[2]^d[3], d[0], d[1]^d[2]^d[3]};
    endfunction

    // Syndrome per flipped position, from R5.
    function automatic logic [2:0] ref_syn(input int pos);
        case (pos)
            1: return 3'b001;
            2: return 3'b110;
            3: return 3'b010;
            4: return 3'b101;
            5: return 3'b100;
            6: return 3'b011;
            7: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] d0, input logic [3:0] d1,
                         input int e0, input int e1);
        exp_t e;
        logic [6:0] c0, c1;
        @(negedge clk);
        c0 = ref_cw(d0);
        c1 = ref_cw(d1);
        tx_data_i  = {d1, d0};
        tx_valid_i = 1'b1;
        e.bus  = {c1, c0};
        if (e0 != 0) c0[e0-1] = ~c0[e0-1];
        if (e1 != 0) c1[e1-1] = ~c1[e1-1];
        rx_bus_i   = {c1, c0};
        rx_valid_i = 1'b1;
        e.data = {d1, d0};
        e.err  = {(e1 != 0), (e0 != 0)};
        e.syn  = {ref_syn(e1), ref_syn(e0)};
        e.par_hit = {(e1 == 1 || e1 == 3 || e1 == 5), (e0 == 1 || e0 == 3 || e0 == 5)};
        sb_q.push_back(e);
    endtask

    // Monitor: outputs are one cycle behind the driver (R3).
    always @(negedge clk) begin
        if (!rst && rx_valid_o) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R3", "unexpected rx valid", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(bus_valid_o == 1'b1, "R3", "bus valid", {15'd0, bus_valid_o}, 16'd1);
                check(bus_o[6:0] == e.bus[6:0], "R2", "lane0 codeword", {9'd0, bus_o[6:0]}, {9'd0, e.bus[6:0]});
                check(bus_o[13:7] == e.bus[13:7], "R10", "lane1 codeword", {9'd0, bus_o[13:7]}, {9'd0, e.bus[13:7]});
                for (int k = 0; k < LANES; k++) begin
                    string tag;
                    if (!e.err[k]) tag = "R4";
                    else if (e.par_hit[k]) tag = "R7";
                    else tag = "R6";
                    check(rx_data_o[k*4 +: 4] == e.data[k*4 +: 4], tag, "data",
                          {12'd0, rx_data_o[k*4 +: 4]}, {12'd0, e.data[k*4 +: 4]});
                    check(rx_err_o[k] == e.err[k], tag, "error flag",
                          {15'd0, rx_err_o[k]}, {15'd0, e.err[k]});
                    check(rx_syn_o[k*3 +: 3] == e.syn[k*3 +: 3], "R5", "syndrome",
                          {13'd0, rx_syn_o[k*3 +: 3]}, {13'd0, e.syn[k*3 +: 3]});
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [BW-1:0] snap_bus;
        logic [DW-1:0] snap_data;
        logic [SW-1:0] snap_syn;

        repeat (2) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check(bus_o == '0 && bus_valid_o == 1'b0, "R8", "bus after reset", {2'd0, bus_o}, 16'd0);
        check(rx_data_o == '0 && rx_valid_o == 1'b0 && rx_err_o == '0 && rx_syn_o == '0,
              "R8", "rx after reset", {8'd0, rx_data_o}, 16'd0);
        rst = 1'b0;

        for (int d = 0; d < 16; d++) begin
            for (int e = 0; e < 8; e++) begin
                drive(4'(d), ~4'(d), e, (e + 3) % 8);
            end
            @(negedge clk);
            tx_valid_i = 1'b0;
            rx_valid_i = 1'b0;
        end
        @(negedge clk);
        tx_valid_i = 1'b0;
        rx_valid_i = 1'b0;
        @(negedge clk);
        check(sb_q.size() == 0, "R3", "pending results", 16'(sb_q.size()), 16'd0);

        // R9: idle inputs leave registered outputs untouched
        snap_bus  = bus_o;
        snap_data = rx_data_o;
        snap_syn  = rx_syn_o;
        tx_data_i = 8'hA5;
        rx_bus_i  = 14'h2B6D;
        @(negedge clk);
        check(bus_o == snap_bus && bus_valid_o == 1'b0, "R9", "bus hold", {2'd0, bus_o}, {2'd0, snap_bus});
        check(rx_data_o == snap_data && rx_syn_o == snap_syn && rx_valid_o == 1'b0,
              "R9", "rx hold", {8'd0, rx_data_o}, {8'd0, snap_data});

        // R8: reset in mid-run
        drive(4'h9, 4'h6, 2, 0);
        rst = 1'b1;
        @(negedge clk);
        sb_q.delete();
        tx_valid_i = 1'b0;
        rx_valid_i = 1'b0;
        check(bus_o == '0 && bus_valid_o == 1'b0, "R8", "bus after late reset", {2'd0, bus_o}, 16'd0);
        check(rx_data_o == '0 && rx_err_o == '0 && rx_syn_o == '0 && rx_valid_o == 1'b0,
              "R8", "rx after late reset", {8'd0, rx_data_o}, 16'd0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule